// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Per-Word Valid Bits

This block is a direct-mapped data cache. It holds 64 KB of data in lines of four 32-bit words, which gives 4096 lines. A processor port carries single-word loads and stores with a valid/ready handshake. A memory port moves whole lines: reads for fills and masked writes for writebacks. Each processor byte address is split into three fields. Bits [3:2] pick the word within the line, bits [15:4] pick the line, and bits [31:16] are the tag kept beside the line.

A store that misses takes the line without reading memory. It writes only the addressed word and marks only that word valid, so every word carries its own valid bit and dirty bit. A load returns at once when the tag matches and the addressed word is valid. Any other load fetches the whole line. A fill into a line that already holds the same tag keeps the words that are valid and dirty, and takes the other words from memory. A line with any dirty word is written back before another tag replaces it. The writeback carries a per-word mask, so words that were never valid do not overwrite memory.

Top module: `dm_wordvalid_cache`

## Requirements
- R1: The word offset is byte address bits [3:2], the line index is bits [15:4] and the tag is bits [31:16]. The byte address of word 17003 (68012) maps to offset 3, index 154 and tag 1. Its fill request uses the line-aligned address 68000, and it conflicts with byte address 68012+65536. Request addresses have bits [1:0] equal to zero.
- R2: `req_ready_o` is high whenever no memory transaction is pending. It is low while a fill or a writeback is in progress.
- R3: A load hit raises `rsp_valid_o` in the cycle after acceptance, with the stored word on `rsp_rdata_o`. It causes no memory request.
- R4: A load miss issues one line read at the line-aligned address. On `mem_rdata_i`, word w sits at bits [32w+31:32w]. The filled line is fully valid. With strictly sequential word loads, 3 of every 4 hit.
- R5: A store whose tag matches a line with at least one valid word updates the word and acknowledges with `rsp_valid_o` in the next cycle. It causes no memory traffic.
- R6: A store miss onto a line without dirty words allocates the line with no memory request. Only the stored word becomes valid, so a later load of a neighbour word in that line triggers a fill.
- R7: A fill into a line whose tag matches keeps every valid dirty word. Later loads of those words return the stored values.
- R8: Replacing a line that holds a dirty word under another tag first issues a line write. That write carries the old tag and index, and a mask whose bit w is set exactly for the valid dirty word w. The fill follows it.
- R9: Replacing a line that has no dirty word issues no writeback.
- R10: A store miss onto a line with dirty words writes the victim back, then allocates the stored word with no fill.
- R11: After reset all lines are invalid, `rsp_valid_o` and `mem_req_valid_o` are low, and a memory request is held stable until `mem_req_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Byte address, word aligned |
| req_wdata_i | input | 32 | Store data |
| req_ready_o | output | 1 | Request accepted when high with valid |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 32 | Load data, valid with rsp_valid_o on loads |
| mem_req_valid_o | output | 1 | Memory line request valid |
| mem_req_write_o | output | 1 | 1 = writeback, 0 = fill read |
| mem_req_addr_o | output | 32 | Line-aligned byte address |
| mem_wdata_o | output | 128 | Writeback line, word w at bits [32w+31:32w] |
| mem_wmask_o | output | 4 | Per-word write enables for the writeback |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Fill data valid |
| mem_rdata_i | input | 128 | Fill line, word w at bits [32w+31:32w] |

## Verification
The bench starts with a cold miss on word 17003 and a strictly sequential sweep of 64 words. The sweep tells the address split and the 3-in-4 hit rate apart from a design that refills on every word. Targeted store sequences follow. A store miss, then a neighbour load, then an eviction separates write-no-fetch allocation, dirty-word merging on fill and masked writeback. A store onto a dirty victim separates eviction-then-allocate from eviction-then-fill. A closing grid of mixed stores and loads over four tags that share sixteen lines compares every load against an arithmetic shadow of memory. That check catches lost or stale words wherever the policies interact.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL_REQ,
    ST_FILL_WAIT
  } cache_state_e;
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
  parameter int WADDR_W = 30,
  parameter int OFF_W   = 2,
  parameter int IDX_W   = 12,
  localparam int TAG_W  = WADDR_W - IDX_W - OFF_W
) (
  input  logic [WADDR_W-1:0] waddr_i,
  output logic [OFF_W-1:0]   off_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [TAG_W-1:0]   tag_o
);
  assign off_o = waddr_i[OFF_W-1:0];
  assign idx_o = waddr_i[OFF_W+IDX_W-1:OFF_W];
  assign tag_o = waddr_i[WADDR_W-1:OFF_W+IDX_W];
endmodule

// File: rtl/cache_store.sv
module cache_store #(
  parameter int NUM_LINES  = 4096,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 16,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int LINE_W    = LINE_WORDS * DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [TAG_W-1:0]      rd_tag_o,
  output logic [LINE_W-1:0]     rd_data_o,
  output logic [LINE_WORDS-1:0] rd_valid_o,
  output logic [LINE_WORDS-1:0] rd_dirty_o,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [TAG_W-1:0]      wr_tag_i,
  input  logic [LINE_W-1:0]     wr_data_i,
  input  logic [LINE_WORDS-1:0] wr_valid_i,
  input  logic [LINE_WORDS-1:0] wr_dirty_i
);
  logic [TAG_W-1:0]      tag_q   [NUM_LINES];
  logic [LINE_W-1:0]     data_q  [NUM_LINES];
  logic [LINE_WORDS-1:0] valid_q [NUM_LINES];
  logic [LINE_WORDS-1:0] dirty_q [NUM_LINES];

  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        valid_q[i] <= '0;
        dirty_q[i] <= '0;
      end
    end else if (we_i) begin
      valid_q[wr_idx_i] <= wr_valid_i;
      dirty_q[wr_idx_i] <= wr_dirty_i;
    end
  end

  // a dirty word must always be a valid word
  p_dirty_in_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> ((wr_dirty_i & ~wr_valid_i) == '0));
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 4096,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int WADDR_W   = ADDR_W - 2,
  localparam int TAG_W     = WADDR_W - IDX_W - OFF_W,
  localparam int LINE_W    = LINE_WORDS * DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  output logic                  req_ready_o,
  output logic                  rsp_valid_o,
  output logic [DATA_W-1:0]     rsp_rdata_o,
  output logic                  mem_req_valid_o,
  output logic                  mem_req_write_o,
  output logic [ADDR_W-1:0]     mem_req_addr_o,
  output logic [LINE_W-1:0]     mem_wdata_o,
  output logic [LINE_WORDS-1:0] mem_wmask_o,
  input  logic                  mem_req_ready_i,
  input  logic                  mem_rsp_valid_i,
  input  logic [LINE_W-1:0]     mem_rdata_i,
  output logic [IDX_W-1:0]      lk_idx_o,
  input  logic [TAG_W-1:0]      lk_tag_i,
  input  logic [LINE_W-1:0]     lk_data_i,
  input  logic [LINE_WORDS-1:0] lk_valid_i,
  input  logic [LINE_WORDS-1:0] lk_dirty_i,
  output logic                  st_we_o,
  output logic [IDX_W-1:0]      st_idx_o,
  output logic [TAG_W-1:0]      st_tag_o,
  output logic [LINE_W-1:0]     st_data_o,
  output logic [LINE_WORDS-1:0] st_valid_o,
  output logic [LINE_WORDS-1:0] st_dirty_o
);
  cache_state_e state_q, state_d;

  logic [ADDR_W-1:0] h_addr_q;
  logic              h_write_q;
  logic [DATA_W-1:0] h_wdata_q;

  logic [OFF_W-1:0] req_off, h_off, cur_off;
  logic [IDX_W-1:0] req_idx, h_idx, cur_idx;
  logic [TAG_W-1:0] req_tag, h_tag, cur_tag;
  logic              cur_write;
  logic [DATA_W-1:0] cur_wdata;

  cache_addr_split #(.WADDR_W(WADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_split_req (
    .waddr_i(req_addr_i[ADDR_W-1:2]), .off_o(req_off), .idx_o(req_idx), .tag_o(req_tag));
  cache_addr_split #(.WADDR_W(WADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_split_held (
    .waddr_i(h_addr_q[ADDR_W-1:2]), .off_o(h_off), .idx_o(h_idx), .tag_o(h_tag));

  logic idle;
  assign idle      = (state_q == ST_IDLE);
  assign cur_off   = idle ? req_off : h_off;
  assign cur_idx   = idle ? req_idx : h_idx;
  assign cur_tag   = idle ? req_tag : h_tag;
  assign cur_write = idle ? req_write_i : h_write_q;
  assign cur_wdata = idle ? req_wdata_i : h_wdata_q;
  assign lk_idx_o  = cur_idx;

  logic                  tag_eq, word_ok, victim_dirty;
  logic [LINE_WORDS-1:0] off_1h, keep, base_valid, base_dirty;
  logic [LINE_W-1:0]     store_line, fill_line;
  logic [DATA_W-1:0]     lk_word  [LINE_WORDS];
  logic [DATA_W-1:0]     fill_word[LINE_WORDS];

  assign tag_eq       = (lk_tag_i == cur_tag) && (|lk_valid_i);
  assign word_ok      = tag_eq && lk_valid_i[cur_off];
  assign victim_dirty = !tag_eq && (|(lk_valid_i & lk_dirty_i));
  assign off_1h       = LINE_WORDS'(1) << cur_off;
  assign keep         = tag_eq ? (lk_valid_i & lk_dirty_i) : '0;
  assign base_valid   = tag_eq ? lk_valid_i : '0;
  assign base_dirty   = tag_eq ? lk_dirty_i : '0;

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    assign lk_word[w]   = lk_data_i[w*DATA_W +: DATA_W];
    assign fill_word[w] = keep[w] ? lk_word[w] : mem_rdata_i[w*DATA_W +: DATA_W];
    assign store_line[w*DATA_W +: DATA_W] = (cur_off == OFF_W'(w)) ? cur_wdata : lk_word[w];
    assign fill_line[w*DATA_W +: DATA_W]  = fill_word[w];
  end

  logic              rsp_set;
  logic [DATA_W-1:0] rsp_word;

  always_comb begin
    state_d         = state_q;
    st_we_o         = 1'b0;
    st_idx_o        = cur_idx;
    st_tag_o        = cur_tag;
    st_data_o       = store_line;
    st_valid_o      = base_valid | off_1h;
    st_dirty_o      = base_dirty | off_1h;
    mem_req_valid_o = 1'b0;
    mem_req_write_o = 1'b0;
    mem_req_addr_o  = {cur_tag, cur_idx, {(OFF_W+2){1'b0}}};
    mem_wdata_o     = lk_data_i;
    mem_wmask_o     = lk_valid_i & lk_dirty_i;
    rsp_set         = 1'b0;
    rsp_word        = lk_word[cur_off];
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (victim_dirty && (cur_write || !word_ok)) begin
            state_d = ST_WB;
          end else if (cur_write) begin
            st_we_o = 1'b1;
            rsp_set = 1'b1;
          end else if (word_ok) begin
            rsp_set = 1'b1;
          end else begin
            state_d = ST_FILL_REQ;
          end
        end
      end
      ST_WB: begin
        mem_req_valid_o = 1'b1;
        mem_req_write_o = 1'b1;
        mem_req_addr_o  = {lk_tag_i, cur_idx, {(OFF_W+2){1'b0}}};
        if (mem_req_ready_i) begin
          if (cur_write) begin
            st_we_o = 1'b1;
            rsp_set = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_FILL_REQ;
          end
        end
      end
      ST_FILL_REQ: begin
        mem_req_valid_o = 1'b1;
        if (mem_req_ready_i) state_d = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (mem_rsp_valid_i) begin
          st_we_o    = 1'b1;
          st_data_o  = fill_line;
          st_valid_o = '1;
          st_dirty_o = keep;
          rsp_set    = 1'b1;
          rsp_word   = fill_word[cur_off];
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign req_ready_o = idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      h_addr_q    <= '0;
      h_write_q   <= 1'b0;
      h_wdata_q   <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_o <= rsp_set;
      if (idle && req_valid_i) begin
        h_addr_q  <= req_addr_i;
        h_write_q <= req_write_i;
        h_wdata_q <= req_wdata_i;
      end
      if (rsp_set && !cur_write) rsp_rdata_o <= rsp_word;
    end
  end

  p_word_aligned_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (req_addr_i[1:0] == 2'b00));
  p_busy_not_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);
  p_hit_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_write_i && word_ok) |=> (rsp_valid_o && !mem_req_valid_o));
  p_wb_has_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_write_o) |-> (mem_wmask_o != '0));
  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o)));
  p_rsp_when_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);
endmodule

// File: rtl/dm_wordvalid_cache.sv
module dm_wordvalid_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 4096,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int TAG_W     = ADDR_W - 2 - IDX_W - OFF_W,
  localparam int LINE_W    = LINE_WORDS * DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  output logic                  req_ready_o,
  output logic                  rsp_valid_o,
  output logic [DATA_W-1:0]     rsp_rdata_o,
  output logic                  mem_req_valid_o,
  output logic                  mem_req_write_o,
  output logic [ADDR_W-1:0]     mem_req_addr_o,
  output logic [LINE_W-1:0]     mem_wdata_o,
  output logic [LINE_WORDS-1:0] mem_wmask_o,
  input  logic                  mem_req_ready_i,
  input  logic                  mem_rsp_valid_i,
  input  logic [LINE_W-1:0]     mem_rdata_i
);
  logic [IDX_W-1:0]      lk_idx, st_idx;
  logic [TAG_W-1:0]      lk_tag, st_tag;
  logic [LINE_W-1:0]     lk_data, st_data;
  logic [LINE_WORDS-1:0] lk_valid, lk_dirty, st_valid, st_dirty;
  logic                  st_we;

  cache_store #(
    .NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) i_store (
    .clk_i, .rst_ni,
    .rd_idx_i(lk_idx), .rd_tag_o(lk_tag), .rd_data_o(lk_data),
    .rd_valid_o(lk_valid), .rd_dirty_o(lk_dirty),
    .we_i(st_we), .wr_idx_i(st_idx), .wr_tag_i(st_tag), .wr_data_i(st_data),
    .wr_valid_i(st_valid), .wr_dirty_i(st_dirty)
  );

  cache_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i, .req_ready_o,
    .rsp_valid_o, .rsp_rdata_o,
    .mem_req_valid_o, .mem_req_write_o, .mem_req_addr_o, .mem_wdata_o, .mem_wmask_o,
    .mem_req_ready_i, .mem_rsp_valid_i, .mem_rdata_i,
    .lk_idx_o(lk_idx), .lk_tag_i(lk_tag), .lk_data_i(lk_data),
    .lk_valid_i(lk_valid), .lk_dirty_i(lk_dirty),
    .st_we_o(st_we), .st_idx_o(st_idx), .st_tag_o(st_tag), .st_data_o(st_data),
    .st_valid_o(st_valid), .st_dirty_o(st_dirty)
  );
endmodule

// File: tb/test_dm_wordvalid_cache.sv
module test_dm_wordvalid_cache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic         req_ready, rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         mem_req_valid, mem_req_write;
  logic [31:0]  mem_req_addr;
  logic [127:0] mem_wdata;
  logic [3:0]   mem_wmask;
  logic         mem_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [127:0] mem_rdata = '0;

  always #4 clk = ~clk;

  dm_wordvalid_cache i_dm_wordvalid_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_req_valid_o(mem_req_valid), .mem_req_write_o(mem_req_write),
    .mem_req_addr_o(mem_req_addr), .mem_wdata_o(mem_wdata), .mem_wmask_o(mem_wmask),
    .mem_req_ready_i(mem_ready), .mem_rsp_valid_i(mem_rsp_valid), .mem_rdata_i(mem_rdata)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] memw   [int unsigned];
  logic [31:0] shadow [int unsigned];

  function automatic logic [31:0] init_word(int unsigned wa);
    return (wa * 32'h9E3779B1) ^ 32'hC3A50000;
  endfunction
  function automatic logic [31:0] mem_get(int unsigned wa);
    return memw.exists(wa) ? memw[wa] : init_word(wa);
  endfunction
  function automatic logic [31:0] exp_get(int unsigned wa);
    return shadow.exists(wa) ? shadow[wa] : init_word(wa);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model, acts at negedge
  int n_fill = 0, n_wb = 0, wait_cnt = 0, rsp_cnt = 0;
  logic [31:0]  last_fill_addr = '0, last_wb_addr = '0;
  logic [3:0]   last_wb_mask = '0;
  logic [127:0] rsp_line = '0;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rdata = rsp_line;
      end
    end
    if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (rst_n && mem_req_valid && rsp_cnt == 0 && !mem_rsp_valid) begin
      wait_cnt++;
      if (wait_cnt >= 2) begin
        wait_cnt = 0;
        mem_ready = 1'b1;
        if (mem_req_write) begin
          n_wb++;
          last_wb_addr = mem_req_addr;
          last_wb_mask = mem_wmask;
          for (int w = 0; w < 4; w++)
            if (mem_wmask[w]) memw[(mem_req_addr >> 2) + w] = mem_wdata[w*32 +: 32];
        end else begin
          n_fill++;
          last_fill_addr = mem_req_addr;
          for (int w = 0; w < 4; w++) rsp_line[w*32 +: 32] = mem_get((mem_req_addr >> 2) + w);
          rsp_cnt = 3;
        end
      end
    end
  end

  logic [31:0] rd;
  int lat;

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    rd = rsp_rdata;
    if (wr) shadow[a >> 2] = d;
  endtask

  task automatic load(input logic [31:0] a, input string req);
    access(1'b0, a, '0);
    chk(rd == exp_get(a >> 2), req, $sformatf("load data @%0h", a), rd, exp_get(a >> 2));
  endtask

  int f0, w0, hits;
  logic [31:0] wa_addr, xa_addr, ya_addr, za_addr;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11, R2: reset state
    chk(req_ready == 1'b1, "R2", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R11", "mem_req_valid after reset", mem_req_valid, 0);

    // R1, R4: word 17003 cold miss
    f0 = n_fill; w0 = n_wb;
    load(32'd68012, "R1");
    chk(n_fill == f0 + 1 && n_wb == w0, "R4", "one fill on cold miss", n_fill - f0, 1);
    chk(last_fill_addr == 32'd68000, "R1", "fill line address", last_fill_addr, 68000);
    chk(lat > 1, "R2", "miss waits for memory", lat, 2);

    // R4, R3: sequential sweep
    f0 = n_fill; hits = 0;
    for (int i = 0; i < 64; i++) begin
      load(32'h0040_0000 + 32'(i * 4), "R4");
      if (lat == 1) hits++;
    end
    chk(n_fill - f0 == 16, "R4", "fills in sequential sweep", n_fill - f0, 16);
    chk(hits == 48, "R3", "one-cycle hits in sweep", hits, 48);

    // R5: store hit
    f0 = n_fill; w0 = n_wb;
    access(1'b1, 32'h0040_0004, 32'hDEAD_0001);
    chk(lat == 1, "R5", "store hit ack latency", lat, 1);
    load(32'h0040_0004, "R5");
    chk(n_fill == f0 && n_wb == w0, "R5", "no traffic on store hit", n_fill - f0 + n_wb - w0, 0);

    // R6, R7: store miss allocate then merge fill
    wa_addr = (32'd5 << 16) | (32'd300 << 4) | 32'd4;
    f0 = n_fill; w0 = n_wb;
    access(1'b1, wa_addr, 32'hA5A5_0005);
    chk(n_fill == f0 && n_wb == w0, "R6", "store miss without fetch", n_fill - f0, 0);
    load(wa_addr, "R6");
    chk(lat == 1 && n_fill == f0, "R6", "stored word hits", lat, 1);
    load(wa_addr + 4, "R6");
    chk(n_fill == f0 + 1, "R6", "neighbour word fills", n_fill - f0, 1);
    load(wa_addr, "R7");
    chk(lat == 1 && rd == 32'hA5A5_0005, "R7", "dirty word kept over fill", rd, 32'hA5A5_0005);

    // R8, R9: dirty eviction then clean eviction
    xa_addr = (32'd9 << 16) | (32'd300 << 4);
    f0 = n_fill; w0 = n_wb;
    load(xa_addr, "R8");
    chk(n_wb == w0 + 1 && n_fill == f0 + 1, "R8", "writeback then fill", n_wb - w0, 1);
    chk(last_wb_addr == ((32'd5 << 16) | (32'd300 << 4)), "R8", "writeback address",
        last_wb_addr, (32'd5 << 16) | (32'd300 << 4));
    chk(last_wb_mask == 4'b0010, "R8", "writeback mask", last_wb_mask, 4'b0010);
    w0 = n_wb;
    load(wa_addr, "R9");
    chk(n_wb == w0, "R9", "no writeback of clean line", n_wb - w0, 0);

    // R10: store miss onto dirty line
    ya_addr = (32'd7 << 16) | (32'd500 << 4) | 32'd8;
    za_addr = (32'd8 << 16) | (32'd500 << 4) | 32'd12;
    access(1'b1, ya_addr, 32'h1111_2222);
    f0 = n_fill; w0 = n_wb;
    access(1'b1, za_addr, 32'h3333_4444);
    chk(n_wb == w0 + 1 && n_fill == f0, "R10", "writeback without fill", n_fill - f0, 0);
    chk(last_wb_mask == 4'b0100, "R10", "victim mask", last_wb_mask, 4'b0100);
    load(za_addr, "R10");
    chk(lat == 1, "R10", "allocated word hits", lat, 1);
    load(ya_addr, "R8");
    chk(last_wb_mask == 4'b1000, "R8", "second victim mask", last_wb_mask, 4'b1000);

    // R1, R9: conflict at index 154
    f0 = n_fill; w0 = n_wb;
    load(32'd68012 + 32'd65536, "R1");
    chk(n_wb == w0 && n_fill == f0 + 1, "R9", "clean conflict miss", n_wb - w0, 0);
    chk(last_fill_addr == 32'd68000 + 32'd65536, "R1", "conflict fill address",
        last_fill_addr, 32'd68000 + 32'd65536);

    // R7, R8, R6: mixed grid, four tags over sixteen lines
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 16; i++)
        for (int w = 0; w < 4; w++) begin
          logic [31:0] a;
          a = (32'(20 + t) << 16) | (32'(1000 + i) << 4) | 32'(w * 4);
          if (((t + i + w) % 3) == 0) access(1'b1, a, {16'(t * 64 + i), 16'(w + 7)});
          else load(a, "R7");
        end
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 16; i++)
        for (int w = 0; w < 4; w++)
          load((32'(20 + t) << 16) | (32'(1000 + i) << 4) | 32'(w * 4), "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule